// File: doc/BRIEF.md
# Strobed Overvoltage Fault Filter

This block turns a digitized comparator flag into a clean overvoltage fault for a switching power controller. The flag reports whether a monitored voltage, taken from an auxiliary winding, sits above an overvoltage reference. That voltage only follows the output while the power switch is off, and it rings for a short time after turn-off. The block therefore takes at most one sample of the flag in each off-time. The sample is taken a programmable number of clock cycles after the switch opens, so the ringing is over before the flag is read.

Samples that are over the threshold are counted. The count survives only while every oscillator cycle supplies one. A cycle that ends without an over-threshold sample sets the count back to zero. When the count reaches the trip value, the block emits a one-clock fault pulse. The controller uses that pulse to stop switching and to start its restart sequence. The count then stays at the trip value until the fault is acknowledged. The counter value is brought out for debug.

Top module: `ovp_strobe_filter`

## Requirements
- R1: While `rstN` is low, and on the first clock after it, `tripCount` is 0 and `faultPulse` is 0.
- R2: Off-time begins when `gateOn` is low at a rising clock edge. The flag is sampled on the STROBE_CYC-th consecutive such edge (default 250). If `cmpAbove` is 1 there, `tripCount` rises by exactly 1 at that edge and not at an earlier one.
- R3: No more than one sample is taken per off-time. An off-time of any length with `cmpAbove` held at 1 raises `tripCount` by at most 1.
- R4: `cmpAbove` has no effect at edges where `gateOn` is high, at edges before the strobe edge, and at edges after it within the same off-time.
- R5: When an off-time ends before its strobe edge, no sample is taken. The cycle counts as having no over-threshold sample.
- R6: When `cycleStart` is 1 at an edge and the oscillator cycle that is ending had no over-threshold sample, `tripCount` becomes 0 at that edge. This applies only when `tripCount` is below the trip value.
- R7: An over-threshold sample at the same edge as `cycleStart` counts toward the cycle that is ending. `tripCount` increments and is not cleared at that edge.
- R8: `faultPulse` is 1 for exactly one clock. It rises at the edge where `tripCount` reaches TRIP_COUNT (default 4), which is the TRIP_COUNT-th consecutive over-threshold cycle.
- R9: Once `tripCount` equals TRIP_COUNT, it holds that value. Further samples and missed cycles do not change it, and no further `faultPulse` is produced.
- R10: `faultAck` high at an edge sets `tripCount` to 0 at that edge. It takes priority over a sample taken at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateOn | input | 1 | Power switch drive, 1 while the switch conducts |
| cycleStart | input | 1 | One-clock pulse at the start of each oscillator cycle |
| cmpAbove | input | 1 | Comparator flag, 1 when the monitored voltage is over the reference |
| faultAck | input | 1 | Clears the counter and re-arms the filter |
| faultPulse | output | 1 | One-clock overvoltage fault |
| tripCount | output | CNT_W | Consecutive over-threshold cycle count, for debug |

## Verification
A wrong internal state shows on `tripCount` no later than the next strobe edge or the next `cycleStart`. Three faults are visible this way:
- A delay counter off by one moves the increment one edge early or late.
- A sample-done flag that fails to latch lets a long off-time add more than one count.
- A lost cycle-hit flag clears the count at the cycle boundary where it should be kept.

Faults in trip detection and saturation show on `faultPulse`. It either rises at the wrong count or rises a second time while the count holds at the trip value.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  // Per-edge decisions handed from the sampling control to the counter.
  typedef struct packed {
    logic countUp;   // over-threshold sample taken at this edge
    logic clearRun;  // the ending oscillator cycle had no over-threshold sample
  } ctlStrobes_t;

endpackage

// File: rtl/ovp_strobe_ctrl.sv
module ovp_strobe_ctrl #(
  parameter int STROBE_CYC = 250,
  localparam int DLY_W = $clog2(STROBE_CYC + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     gateOn,
  input  logic                     cycleStart,
  input  logic                     cmpAbove,
  output ovp_pkg::ctlStrobes_t     strobes
);

  logic [DLY_W-1:0] offCnt;      // off-time edges seen so far
  logic             sampleDone;  // the sample of this off-time has been taken
  logic             hitInCycle;  // an over-threshold sample was seen in this cycle
  logic             strobeEdge;
  logic             hitNow;

  // The sample is taken on the STROBE_CYC-th consecutive off edge, once only.
  assign strobeEdge = !gateOn && !sampleDone && (offCnt == DLY_W'(STROBE_CYC - 1));
  assign hitNow     = strobeEdge && cmpAbove;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offCnt     <= '0;
      sampleDone <= 1'b0;
    end else if (gateOn) begin
      offCnt     <= '0;
      sampleDone <= 1'b0;
    end else if (!sampleDone) begin
      if (strobeEdge) begin
        sampleDone <= 1'b1;
      end else begin
        offCnt <= offCnt + DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitInCycle <= 1'b0;
    end else if (cycleStart) begin
      hitInCycle <= 1'b0;
    end else if (hitNow) begin
      hitInCycle <= 1'b1;
    end
  end

  always_comb begin
    strobes.countUp  = hitNow;
    // A hit on the boundary edge still belongs to the ending cycle.
    strobes.clearRun = cycleStart && !hitInCycle && !hitNow;
  end

endmodule

// File: rtl/ovp_trip_counter.sv
module ovp_trip_counter #(
  parameter int TRIP_COUNT = 4,
  localparam int CNT_W = $clog2(TRIP_COUNT + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ovp_pkg::ctlStrobes_t  strobes,
  input  logic                  faultAck,
  output logic [CNT_W-1:0]      tripCount,
  output logic                  faultPulse
);

  logic atTrip;
  logic lastStep;

  assign atTrip   = (tripCount == CNT_W'(TRIP_COUNT));
  assign lastStep = (tripCount == CNT_W'(TRIP_COUNT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tripCount <= '0;
    end else if (faultAck) begin
      tripCount <= '0;
    end else if (atTrip) begin
      tripCount <= tripCount;
    end else if (strobes.countUp) begin
      tripCount <= tripCount + CNT_W'(1);
    end else if (strobes.clearRun) begin
      tripCount <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPulse <= 1'b0;
    end else begin
      faultPulse <= !faultAck && !atTrip && lastStep && strobes.countUp;
    end
  end

endmodule

// File: rtl/ovp_strobe_filter.sv
module ovp_strobe_filter #(
  parameter int STROBE_CYC = 250,
  parameter int TRIP_COUNT = 4,
  localparam int CNT_W = $clog2(TRIP_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateOn,
  input  logic             cycleStart,
  input  logic             cmpAbove,
  input  logic             faultAck,
  output logic             faultPulse,
  output logic [CNT_W-1:0] tripCount
);

  ovp_pkg::ctlStrobes_t strobes;

  ovp_strobe_ctrl #(.STROBE_CYC(STROBE_CYC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .gateOn     (gateOn),
    .cycleStart (cycleStart),
    .cmpAbove   (cmpAbove),
    .strobes    (strobes)
  );

  ovp_trip_counter #(.TRIP_COUNT(TRIP_COUNT)) u_count (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .faultAck   (faultAck),
    .tripCount  (tripCount),
    .faultPulse (faultPulse)
  );

endmodule

// File: rtl/ovp_filter_checker.sv
module ovp_filter_checker #(
  parameter int TRIP_COUNT = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             gateOn,
  input logic             faultAck,
  input logic             faultPulse,
  input logic [CNT_W-1:0] tripCount
);

  // R8
  fault_one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> !faultPulse);

  // R8
  fault_at_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> (tripCount == CNT_W'(TRIP_COUNT)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tripCount != $past(tripCount) && tripCount != '0) |-> (tripCount == $past(tripCount) + CNT_W'(1)));

  // R4
  no_count_while_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tripCount == $past(tripCount) + CNT_W'(1)) |-> !$past(gateOn));

  // R9
  hold_at_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tripCount == CNT_W'(TRIP_COUNT) && !faultAck) |=> (tripCount == CNT_W'(TRIP_COUNT)));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultAck |=> (tripCount == '0));

endmodule

bind ovp_strobe_filter ovp_filter_checker #(.TRIP_COUNT(TRIP_COUNT), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .gateOn     (gateOn),
  .faultAck   (faultAck),
  .faultPulse (faultPulse),
  .tripCount  (tripCount)
);

// File: tb/test_ovp_strobe_filter.sv
module test_ovp_strobe_filter;

  localparam int STRB  = 250;
  localparam int TRIP  = 4;
  localparam int CNT_W = $clog2(TRIP + 1);

  logic clk = 1'b0;
  logic rstN, gateOn, cycleStart, cmpAbove, faultAck;
  logic faultPulse;
  logic [CNT_W-1:0] tripCount;

  int errors = 0;
  int checks = 0;
  int pulseSeen = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ovp_strobe_filter #(.STROBE_CYC(STRB), .TRIP_COUNT(TRIP)) i_ovp_strobe_filter (
    .clk(clk), .rstN(rstN), .gateOn(gateOn), .cycleStart(cycleStart),
    .cmpAbove(cmpAbove), .faultAck(faultAck),
    .faultPulse(faultPulse), .tripCount(tripCount)
  );

  always @(posedge clk) if (rstN && faultPulse) pulseSeen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic g, logic c, logic cs, logic ack);
    gateOn = g; cmpAbove = c; cycleStart = cs; faultAck = ack;
    @(negedge clk);
  endtask

  task automatic onPhase(int n, logic c);
    for (int i = 0; i < n; i++) step(1'b1, c, 1'b0, 1'b0);
  endtask

  task automatic offPhase(int n, logic c);
    for (int i = 0; i < n; i++) step(1'b0, c, 1'b0, 1'b0);
  endtask

  task automatic endCycle();
    step(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic hitPeriod();
    onPhase(5, 1'b0); offPhase(STRB, 1'b1); endCycle();
  endtask

  task automatic missPeriod();
    onPhase(5, 1'b0); offPhase(STRB, 1'b0); endCycle();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 count in reset", int'(tripCount), 0);
    chk("R1 pulse in reset", int'(faultPulse), 0);
    rstN = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 count after release", int'(tripCount), 0);
  endtask

  task automatic t_strobeTiming();
    onPhase(5, 1'b0);
    for (int i = 1; i <= STRB; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0);
      if (i == STRB - 1) chk("R2 no count before strobe edge", int'(tripCount), 0);
      if (i == STRB)     chk("R2 count at strobe edge", int'(tripCount), 1);
    end
    endCycle();
    chk("R2 count kept after hit cycle", int'(tripCount), 1);
  endtask

  task automatic t_oneSample();
    onPhase(5, 1'b0);
    offPhase(3 * STRB, 1'b1);
    chk("R3 one sample in long off-time", int'(tripCount), 2);
    endCycle();
  endtask

  task automatic t_ignored();
    onPhase(40, 1'b1);
    offPhase(STRB - 1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    offPhase(20, 1'b1);
    chk("R4 flag outside strobe ignored", int'(tripCount), 2);
    endCycle();
    chk("R6 cleared after cycle without hit", int'(tripCount), 0);
  endtask

  task automatic t_shortOff();
    hitPeriod(); hitPeriod();
    onPhase(5, 1'b0);
    offPhase(STRB - 1, 1'b1);
    chk("R5 short off-time takes no sample", int'(tripCount), 2);
    endCycle();
    chk("R5 short off-time counts as miss", int'(tripCount), 0);
  endtask

  task automatic t_miss();
    hitPeriod(); hitPeriod(); hitPeriod();
    chk("R6 three hits counted", int'(tripCount), 3);
    missPeriod();
    chk("R6 miss clears count", int'(tripCount), 0);
    chk("R6 no pulse below trip", pulseSeen, 0);
  endtask

  task automatic t_sameEdge();
    onPhase(5, 1'b0);
    offPhase(STRB - 1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 hit on boundary edge counted", int'(tripCount), 1);
    missPeriod();
    chk("R7 next cycle without hit clears", int'(tripCount), 0);
  endtask

  task automatic t_trip();
    int p0 = pulseSeen;
    hitPeriod(); hitPeriod(); hitPeriod();
    chk("R8 no pulse before trip", pulseSeen, p0);
    onPhase(5, 1'b0);
    offPhase(STRB - 1, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 pulse at trip edge", int'(faultPulse), 1);
    chk("R8 count at trip", int'(tripCount), TRIP);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 pulse lasts one clock", int'(faultPulse), 0);
    endCycle();
    hitPeriod();
    missPeriod();
    chk("R9 count holds at trip", int'(tripCount), TRIP);
    chk("R9 single pulse only", pulseSeen, p0 + 1);
  endtask

  task automatic t_ack();
    step(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R10 ack clears count", int'(tripCount), 0);
    hitPeriod();
    chk("R10 counting resumes", int'(tripCount), 1);
    onPhase(5, 1'b0);
    offPhase(STRB - 1, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R10 ack wins over hit", int'(tripCount), 0);
    endCycle();
  endtask

  initial begin
    gateOn = 1'b1; cmpAbove = 1'b0; cycleStart = 1'b0; faultAck = 1'b0; rstN = 1'b0;
    @(negedge clk);
    t_reset();
    t_strobeTiming();
    t_oneSample();
    t_ignored();
    t_shortOff();
    t_miss();
    t_sameEdge();
    t_trip();
    t_ack();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule